// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Arbiter

This block merges the receive, transmit and break interrupt sources of two serial channels, A and B, into one interrupt request line. It holds a six-source pending register and a single shared vector byte that a host reads to learn which source to service. Channel A's sources are steered into the same vector byte as channel B's.

Each channel keeps a pending flag and an in-service flag for receive and for transmit. The in-service flag stops a receive interrupt and a transmit interrupt on the same channel from overwriting each other's vector. When a source is cleared, the vector drops to the "no interrupt" code. If the other source of that channel is still pending, it then takes over the vector.

Set and clear pulses arrive one clock wide. All pins are plain control and status levels; no data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The vector code set is chosen by a status-high mode pin. A change of that pin changes only vectors written by later events.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A channel requests an interrupt only when its config bit 0 (master enable) is 1 and one of these holds: config bit 1 is 1 and transmit is pending; config bits [4:3] are 01 or 10 and receive is pending; its break-enable pin and its break-status pin are both 1.
- R2: `irq` is the OR of the requests of channels A and B, and it follows the state and the configuration pins combinationally.
- R3: `pending` bit 5 is receive A, bit 4 is transmit A, bit 2 is receive B and bit 1 is transmit B. Bits 0, 3, 6 and 7 read 0. A source's bit is 1 from the clock after its set pulse until the clock after its clear pulse.
- R4: With `vec_hi` at 0, the codes are: none 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00.
- R5: With `vec_hi` at 1, the codes are: none 0x60, receive A 0x30, receive B 0x20, transmit A 0x10. Transmit B is 0x00 in both modes.
- R6: A receive set on a channel whose transmit source is in service leaves the vector unchanged, but it still marks receive pending.
- R7: A transmit set on a channel whose receive source is in service leaves the vector unchanged, but it still marks transmit pending.
- R8: A clear writes the "none" code to the vector. If the other source of the same channel is still pending, that source is then put in service and its code is written instead.
- R9: When a set pulse and a clear pulse arrive in the same cycle, the clear is applied first and the set second. A same-cycle clear and set of one source therefore leave it pending.
- R10: Within one cycle, channel A is processed before channel B, and within a channel receive is processed before transmit. When all four sources are set at once on idle channels, the vector shows receive B.
- R11: After reset, `irq` is 0, `pending` is 0x00 and `vector` is 0x06.
- R12: In a cycle with no set or clear pulse, the vector holds, whatever `vec_hi` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_set | input | 2 | Receive-interrupt set pulse; bit 0 channel A, bit 1 channel B |
| rx_clr | input | 2 | Receive-interrupt clear pulse, per channel |
| tx_set | input | 2 | Transmit-interrupt set pulse, per channel |
| tx_clr | input | 2 | Transmit-interrupt clear pulse, per channel |
| int_cfg_a | input | 8 | Channel A interrupt config: bit 0 master, bit 1 transmit enable, bits [4:3] receive mode |
| int_cfg_b | input | 8 | Channel B interrupt config, same layout |
| brk_en | input | 2 | Break-interrupt enable, per channel |
| brk_stat | input | 2 | Break status, per channel |
| vec_hi | input | 1 | Selects the status-high vector codes |
| irq | output | 1 | Combined interrupt request |
| pending | output | 8 | Interrupt-pending register |
| vector | output | 8 | Modified vector byte |

## Verification
The functions that collide are a set and a clear landing in the same cycle. This happens on one source, on the two sources of one channel, or on both channels at once. Each of these races decides which source owns the vector. The stimulus table drives these collisions on purpose: a clear and a set of the same source together, a clear of one channel beside a clear of the other, and all four sets at once. Each result is judged against the fixed order: A before B, clear before set, receive before transmit.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  localparam int NUM_CH  = 2;
  localparam int CFG_W   = 8;
  localparam int VEC_W   = 8;
  localparam int PEND_W  = 8;

  // configuration bit positions
  localparam int CFG_MASTER  = 0;
  localparam int CFG_TXEN    = 1;
  localparam int CFG_RXMODE0 = 3;

  // pending register bit positions
  localparam int PB_EXTB = 0;
  localparam int PB_TXB  = 1;
  localparam int PB_RXB  = 2;
  localparam int PB_EXTA = 3;
  localparam int PB_TXA  = 4;
  localparam int PB_RXA  = 5;

  // vector codes, low and high status placement
  localparam logic [VEC_W-1:0] VL_NONE = 8'h06;
  localparam logic [VEC_W-1:0] VL_RXA  = 8'h0C;
  localparam logic [VEC_W-1:0] VL_RXB  = 8'h04;
  localparam logic [VEC_W-1:0] VL_TXA  = 8'h08;
  localparam logic [VEC_W-1:0] VH_NONE = 8'h60;
  localparam logic [VEC_W-1:0] VH_RXA  = 8'h30;
  localparam logic [VEC_W-1:0] VH_RXB  = 8'h20;
  localparam logic [VEC_W-1:0] VH_TXA  = 8'h10;
  localparam logic [VEC_W-1:0] V_TXB   = 8'h00;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TX   = 2'd2
  } src_e;

  typedef struct packed {
    logic rx_pend;
    logic tx_pend;
    logic rx_svc;
    logic tx_svc;
  } chan_st_t;

  function automatic logic [VEC_W-1:0] vec_code(input src_e src,
                                                input logic is_b,
                                                input logic hi);
    logic [VEC_W-1:0] code;
    code = hi ? VH_NONE : VL_NONE;
    if (src == SRC_RX) begin
      if (is_b) code = hi ? VH_RXB : VL_RXB;
      else      code = hi ? VH_RXA : VL_RXA;
    end else if (src == SRC_TX) begin
      if (is_b) code = V_TXB;
      else      code = hi ? VH_TXA : VL_TXA;
    end
    return code;
  endfunction

endpackage

// File: rtl/irqarb_stage.sv
module irqarb_stage
  import irqarb_pkg::*;
#(
  parameter int CH = 0
) (
  input  chan_st_t         st_in,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             rx_set,
  input  logic             rx_clr,
  input  logic             tx_set,
  input  logic             tx_clr,
  input  logic             hi,
  output chan_st_t         st_out,
  output logic [VEC_W-1:0] vec_out
);

  localparam logic IS_B = (CH != 0);

  logic [VEC_W-1:0] c_none, c_rx, c_tx;
  chan_st_t         s;
  logic [VEC_W-1:0] v;

  assign c_none = vec_code(SRC_NONE, IS_B, hi);
  assign c_rx   = vec_code(SRC_RX,   IS_B, hi);
  assign c_tx   = vec_code(SRC_TX,   IS_B, hi);

  // ordered resolution: rx clear, tx clear, rx set, tx set
  always_comb begin
    s = st_in;
    v = vec_in;
    if (rx_clr) begin
      s.rx_pend = 1'b0;
      s.rx_svc  = 1'b0;
      v         = c_none;
      if (s.tx_pend && !s.rx_svc) begin
        s.tx_svc = 1'b1;
        v        = c_tx;
      end
    end
    if (tx_clr) begin
      s.tx_pend = 1'b0;
      s.tx_svc  = 1'b0;
      v         = c_none;
      if (s.rx_pend && !s.tx_svc) begin
        s.rx_svc = 1'b1;
        v        = c_rx;
      end
    end
    if (rx_set) begin
      s.rx_pend = 1'b1;
      if (!s.tx_svc) begin
        s.rx_svc = 1'b1;
        v        = c_rx;
      end
    end
    if (tx_set) begin
      s.tx_pend = 1'b1;
      if (!s.rx_svc) begin
        s.tx_svc = 1'b1;
        v        = c_tx;
      end
    end
  end

  assign st_out  = s;
  assign vec_out = v;

endmodule

// File: rtl/irqarb_req.sv
module irqarb_req
  import irqarb_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  chan_st_t         st,
  input  logic             brk_en,
  input  logic             brk_stat,
  output logic             req
);

  logic [1:0] rx_mode;
  logic       rx_mode_ok;
  logic       unused_cfg_bits;

  assign rx_mode    = cfg[CFG_RXMODE0 +: 2];
  assign rx_mode_ok = (rx_mode == 2'b01) || (rx_mode == 2'b10);

  assign req = cfg[CFG_MASTER] &&
               ((cfg[CFG_TXEN] && st.tx_pend) ||
                (rx_mode_ok && st.rx_pend) ||
                (brk_en && brk_stat));

  assign unused_cfg_bits = ^{cfg[CFG_W-1:CFG_RXMODE0+2], cfg[CFG_RXMODE0-1:CFG_TXEN+1],
                             st.rx_svc, st.tx_svc};

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rx_set,
  input  logic [NUM_CH-1:0] rx_clr,
  input  logic [NUM_CH-1:0] tx_set,
  input  logic [NUM_CH-1:0] tx_clr,
  input  logic [CFG_W-1:0]  int_cfg_a,
  input  logic [CFG_W-1:0]  int_cfg_b,
  input  logic [NUM_CH-1:0] brk_en,
  input  logic [NUM_CH-1:0] brk_stat,
  input  logic              vec_hi,
  output logic              irq,
  output logic [PEND_W-1:0] pending,
  output logic [VEC_W-1:0]  vector
);

  chan_st_t         st_q   [NUM_CH];
  chan_st_t         st_d   [NUM_CH];
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] vec_chain [NUM_CH+1];
  logic [CFG_W-1:0] cfg    [NUM_CH];
  logic [NUM_CH-1:0] req;
  logic             any_evt;

  assign cfg[0]       = int_cfg_a;
  assign cfg[1]       = int_cfg_b;
  assign vec_chain[0] = vec_q;
  assign any_evt      = |{rx_set, rx_clr, tx_set, tx_clr};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    irqarb_stage #(.CH(g)) i_stage (
      .st_in  (st_q[g]),
      .vec_in (vec_chain[g]),
      .rx_set (rx_set[g]),
      .rx_clr (rx_clr[g]),
      .tx_set (tx_set[g]),
      .tx_clr (tx_clr[g]),
      .hi     (vec_hi),
      .st_out (st_d[g]),
      .vec_out(vec_chain[g+1])
    );

    irqarb_req i_req (
      .cfg     (cfg[g]),
      .st      (st_q[g]),
      .brk_en  (brk_en[g]),
      .brk_stat(brk_stat[g]),
      .req     (req[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= '0;
      else        st_q[g] <= st_d[g];
    end

    // R9: a set pulse always leaves its source pending
    a_r9_set_leaves_pending: assert property (@(posedge clk) disable iff (!rst_n)
      rx_set[g] |=> st_q[g].rx_pend);

    // R8: a clear without a set removes the source
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_clr[g] && !tx_set[g]) |=> !st_q[g].tx_pend);

    // R6 / R7: at most one source of a channel is in service
    a_r6_svc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_q[g].rx_svc && st_q[g].tx_svc));

    // R6: receive set alone cannot steal the vector from transmit in service
    a_r6_rx_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g].tx_svc && rx_set == NUM_CH'(1 << g) && rx_clr == '0 &&
       tx_set == '0 && tx_clr == '0) |=> $stable(vec_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= VL_NONE;
    else        vec_q <= vec_chain[NUM_CH];
  end

  always_comb begin
    pending          = '0;
    pending[PB_RXA]  = st_q[0].rx_pend;
    pending[PB_TXA]  = st_q[0].tx_pend;
    pending[PB_RXB]  = st_q[1].rx_pend;
    pending[PB_TXB]  = st_q[1].tx_pend;
    pending[PB_EXTA] = 1'b0;
    pending[PB_EXTB] = 1'b0;
  end

  assign irq    = |req;
  assign vector = vec_q;

  // R12: without events the vector holds
  a_r12_vector_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(vector));

  // R1 / R2: no master enable anywhere, no request
  a_r2_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_cfg_a[CFG_MASTER] && !int_cfg_b[CFG_MASTER]) |-> !irq);

endmodule

// File: tb/test_irq_vector_arbiter.sv
module test_irq_vector_arbiter;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NSTEP      = 17;

  typedef struct packed {
    logic [1:0] rs, rc, ts, tc;
    logic       hi;
    logic [7:0] vec;
    logic [7:0] pend;
    logic       irq;
    logic [3:0] tag;
  } step_t;

  // state carries across rows; config 0x13 on both channels
  localparam step_t TBL [NSTEP] = '{
    '{2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 8'h0C, 8'h20, 1'b1, 4'd4},  // R4 rx A
    '{2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 8'h0C, 8'h30, 1'b1, 4'd7},  // R7 tx A blocked
    '{2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 8'h08, 8'h10, 1'b1, 4'd8},  // R8 tx takes over
    '{2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 8'h08, 8'h30, 1'b1, 4'd6},  // R6 rx blocked
    '{2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 8'h0C, 8'h20, 1'b1, 4'd8},  // R8 rx takes over
    '{2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 8'h06, 8'h00, 1'b0, 4'd8},  // R8 none
    '{2'b00, 2'b00, 2'b10, 2'b00, 1'b0, 8'h00, 8'h02, 1'b1, 4'd4},  // R4 tx B
    '{2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 8'h06, 1'b1, 4'd6},  // R6 rx B blocked
    '{2'b00, 2'b00, 2'b00, 2'b10, 1'b0, 8'h04, 8'h04, 1'b1, 4'd8},  // R8 rx B over
    '{2'b10, 2'b10, 2'b00, 2'b00, 1'b0, 8'h04, 8'h04, 1'b1, 4'd9},  // R9 clr+set
    '{2'b00, 2'b10, 2'b00, 2'b00, 1'b0, 8'h06, 8'h00, 1'b0, 4'd8},  // R8
    '{2'b01, 2'b00, 2'b00, 2'b00, 1'b1, 8'h30, 8'h20, 1'b1, 4'd5},  // R5 rx A hi
    '{2'b00, 2'b00, 2'b10, 2'b00, 1'b1, 8'h00, 8'h22, 1'b1, 4'd5},  // R5 tx B hi
    '{2'b00, 2'b01, 2'b00, 2'b10, 1'b1, 8'h60, 8'h00, 1'b0, 4'd5},  // R5 none hi
    '{2'b11, 2'b00, 2'b11, 2'b00, 1'b1, 8'h20, 8'h36, 1'b1, 4'd10}, // R10 all sets
    '{2'b00, 2'b00, 2'b00, 2'b11, 1'b0, 8'h04, 8'h24, 1'b1, 4'd8},  // R8 both tx clr
    '{2'b00, 2'b11, 2'b00, 2'b00, 1'b0, 8'h06, 8'h00, 1'b0, 4'd8}   // R8 idle
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0;
  logic [7:0] int_cfg_a = 8'h13, int_cfg_b = 8'h13;
  logic [1:0] brk_en = '0, brk_stat = '0;
  logic       vec_hi = 1'b0;
  logic       irq;
  logic [7:0] pending, vector;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  irq_vector_arbiter i_irq_vector_arbiter (
    .clk, .rst_n, .rx_set, .rx_clr, .tx_set, .tx_clr,
    .int_cfg_a, .int_cfg_b, .brk_en, .brk_stat, .vec_hi,
    .irq, .pending, .vector
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] rs, rc, ts, tc);
    rx_set = rs; rx_clr = rc; tx_set = ts; tx_clr = tc;
    @(negedge clk);
    rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 irq",     {7'b0, irq}, 8'h00);
    check("R11 pending", pending,     8'h00);
    check("R11 vector",  vector,      8'h06);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      vec_hi = TBL[i].hi;
      pulse(TBL[i].rs, TBL[i].rc, TBL[i].ts, TBL[i].tc);
      check($sformatf("R%0d step %0d vector", TBL[i].tag, i), vector, TBL[i].vec);
      check($sformatf("R3 step %0d pending", i), pending, TBL[i].pend);
      check($sformatf("R2 step %0d irq", i), {7'b0, irq}, {7'b0, TBL[i].irq});
    end

    // R12: mode flips with no events leave the vector alone
    vec_hi = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 vector hold", vector, 8'h06);
    vec_hi = 1'b0;

    // R1: receive-mode gating
    int_cfg_a = 8'h03;
    pulse(2'b01, 2'b00, 2'b00, 2'b00);
    check("R1 rx mode 00 pending", pending, 8'h20);
    check("R1 rx mode 00 irq", {7'b0, irq}, 8'h00);
    int_cfg_a = 8'h1B; #1;
    check("R1 rx mode 11 irq", {7'b0, irq}, 8'h00);
    int_cfg_a = 8'h0B; #1;
    check("R1 rx mode 01 irq", {7'b0, irq}, 8'h01);
    int_cfg_a = 8'h0A; #1;
    check("R1 master off irq", {7'b0, irq}, 8'h00);
    @(negedge clk);
    pulse(2'b00, 2'b01, 2'b00, 2'b00);
    // R1: transmit-enable gating
    int_cfg_a = 8'h11;
    pulse(2'b00, 2'b00, 2'b01, 2'b00);
    check("R1 tx disabled irq", {7'b0, irq}, 8'h00);
    check("R4 tx A vector", vector, 8'h08);
    int_cfg_a = 8'h13; #1;
    check("R1 tx enabled irq", {7'b0, irq}, 8'h01);
    @(negedge clk);
    pulse(2'b00, 2'b00, 2'b00, 2'b01);
    check("R1 tx cleared irq", {7'b0, irq}, 8'h00);

    // R1 / R2: break request on channel B alone
    int_cfg_a = 8'h00; int_cfg_b = 8'h01;
    brk_en = 2'b10; brk_stat = 2'b10; #1;
    check("R2 break B irq", {7'b0, irq}, 8'h01);
    brk_en = 2'b00; #1;
    check("R1 break disabled irq", {7'b0, irq}, 8'h00);
    brk_en = 2'b10; brk_stat = 2'b00; #1;
    check("R1 break no status irq", {7'b0, irq}, 8'h00);
    @(negedge clk);

    // R5: transmit A in status-high placement
    int_cfg_a = 8'h13; vec_hi = 1'b1;
    pulse(2'b00, 2'b00, 2'b01, 2'b00);
    check("R5 tx A hi vector", vector, 8'h10);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule